// File: doc/BRIEF.md
# Ternary Max/Min Cell with Three-Flavour Inversion

This combinational cell operates on three-valued digits carried as two-bit codes. Two operand trits are combined into one intermediate trit. In inverted-OR behaviour the intermediate trit is the larger operand. In inverted-AND behaviour it is the smaller operand. A select input chooses between the two.

The intermediate trit then feeds three inverters at once. The negative inverter returns 2 only for a zero input. The standard inverter mirrors the value about 1. The positive inverter returns 2 for every value except 2. Each inverter has its own output port.

Two helpers sit beside the core. A single-trit decoder turns one trit into three one-hot level flags. An encoder rebuilds a trit from two binary control lines, so that a binary control network can steer a ternary output. A code outside the legal set raises an error flag instead of producing a value. The cell holds no state: every output follows the current inputs within the same cycle.

Top module: `tern_gate_unit`

## Requirements
- R1: Trit codes are 2'b00 for 0, 2'b01 for 1 and 2'b10 for 2. With `sel_min` low the intermediate trit is the larger operand; with `sel_min` high it is the smaller operand.
- R2: `inv_neg` is 2'b10 when the intermediate trit is 0, and 2'b00 when it is 1 or 2.
- R3: `inv_std` is 2 minus the intermediate trit: 0 gives 2'b10, 1 gives 2'b01 and 2 gives 2'b00.
- R4: `inv_pos` is 2'b00 when the intermediate trit is 2, and 2'b10 when it is 0 or 1.
- R5: If either operand carries the code 2'b11, `op_err` is 1 and all three inverter outputs are 2'b00, whatever `sel_min` is. With two legal operands `op_err` is 0.
- R6: For a legal `dec_in`, exactly one bit of `dec_flags` is set: bit 0 for value 0, bit 1 for value 1, bit 2 for value 2. `dec_err` is 0.
- R7: For `dec_in` equal to 2'b11, `dec_flags` is 3'b000 and `dec_err` is 1.
- R8: `enc_out` is 2'b00 when `enc_lo` and `enc_hi` are both low, 2'b01 when only `enc_lo` is high, and 2'b10 whenever `enc_hi` is high, whatever `enc_lo` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_min | input | 1 | 0 selects the larger operand, 1 selects the smaller |
| opa | input | 2 | First operand trit code |
| opb | input | 2 | Second operand trit code |
| inv_neg | output | 2 | Negative inversion of the intermediate trit |
| inv_std | output | 2 | Standard inversion of the intermediate trit |
| inv_pos | output | 2 | Positive inversion of the intermediate trit |
| op_err | output | 1 | An operand carries the illegal code |
| dec_in | input | 2 | Trit code to decode |
| dec_flags | output | 3 | One-hot level flags, bit k set for value k |
| dec_err | output | 1 | Decoder input carries the illegal code |
| enc_lo | input | 1 | Encoder control line for value 1 |
| enc_hi | input | 1 | Encoder control line for value 2, dominant |
| enc_out | output | 2 | Rebuilt trit code |

## Verification
The cell is combinational, so a wrong internal intermediate trit appears on the inverter ports in the same cycle that the operands settle. A wrong selection between larger and smaller operand shows up as disagreement with the reference for mixed operand pairs. Pairs with equal operands cannot reveal it, so every one of the nine pairs is applied under both selections. A lost error path shows as a non-zero inverter output or a clear `op_err` while an operand holds 2'b11. A slipped decoder flag shows as a flag on the wrong level at once.

// File: rtl/tern_pkg.sv
`timescale 1ns/1ps
package tern_pkg;
    localparam int TRIT_W   = 2;
    localparam int N_LEVELS = 3;

    typedef enum logic [TRIT_W-1:0] {
        TR_ZERO = 2'b00,
        TR_ONE  = 2'b01,
        TR_TWO  = 2'b10,
        TR_BAD  = 2'b11
    } trit_e;
endpackage

// File: rtl/tern_minmax.sv
`timescale 1ns/1ps
module tern_minmax
    import tern_pkg::*;
(
    input  logic              sel_min,
    input  logic [TRIT_W-1:0] opa,
    input  logic [TRIT_W-1:0] opb,
    output trit_e             mid,
    output logic              bad
);
    logic a_bad;
    logic b_bad;
    logic a_gt_b;

    assign a_bad  = (trit_e'(opa) == TR_BAD);
    assign b_bad  = (trit_e'(opb) == TR_BAD);
    assign a_gt_b = (opa > opb);
    assign bad    = a_bad | b_bad;

    always_comb begin
        if (bad) begin
            mid = TR_BAD;
        end else if (sel_min) begin
            mid = a_gt_b ? trit_e'(opb) : trit_e'(opa);
        end else begin
            mid = a_gt_b ? trit_e'(opa) : trit_e'(opb);
        end
    end

    // R1: the chosen trit is one of the operands and bounds both of them
    always_comb begin
        if (!$isunknown({sel_min, opa, opb}) && !bad) begin
            a_r1_pick: assert ((mid == trit_e'(opa) || mid == trit_e'(opb)) &&
                               (sel_min ? (mid <= opa && mid <= opb)
                                        : (mid >= opa && mid >= opb)))
                else $error("intermediate trit does not bound the operands");
        end
    end
endmodule

// File: rtl/tern_inv3.sv
`timescale 1ns/1ps
module tern_inv3
    import tern_pkg::*;
(
    input  trit_e             mid,
    output logic [TRIT_W-1:0] inv_neg,
    output logic [TRIT_W-1:0] inv_std,
    output logic [TRIT_W-1:0] inv_pos
);
    always_comb begin
        unique case (mid)
            TR_ZERO: begin
                inv_neg = TR_TWO;
                inv_std = TR_TWO;
                inv_pos = TR_TWO;
            end
            TR_ONE: begin
                inv_neg = TR_ZERO;
                inv_std = TR_ONE;
                inv_pos = TR_TWO;
            end
            TR_TWO: begin
                inv_neg = TR_ZERO;
                inv_std = TR_ZERO;
                inv_pos = TR_ZERO;
            end
            TR_BAD: begin
                inv_neg = TR_ZERO;
                inv_std = TR_ZERO;
                inv_pos = TR_ZERO;
            end
        endcase
    end

    // R2, R3, R4: the three flavours stay ordered neg <= std <= pos
    always_comb begin
        if (!$isunknown(mid)) begin
            a_r3_order: assert (inv_neg <= inv_std && inv_std <= inv_pos)
                else $error("inverter flavours out of order");
            a_r4_pos_two_level: assert (inv_pos != TR_ONE && inv_neg != TR_ONE)
                else $error("two-level inverter produced value 1");
        end
    end
endmodule

// File: rtl/tern_decode.sv
`timescale 1ns/1ps
module tern_decode
    import tern_pkg::*;
(
    input  logic [TRIT_W-1:0]   dec_in,
    output logic [N_LEVELS-1:0] dec_flags,
    output logic                dec_err
);
    for (genvar k = 0; k < N_LEVELS; k++) begin : g_level
        assign dec_flags[k] = (dec_in == TRIT_W'(k));
    end

    assign dec_err = (trit_e'(dec_in) == TR_BAD);

    // R6, R7: at most one flag, and exactly one unless the code is illegal
    always_comb begin
        if (!$isunknown(dec_in)) begin
            a_r6_onehot: assert ($onehot0(dec_flags) && ((dec_flags != '0) != dec_err))
                else $error("decoder flags inconsistent with error");
        end
    end
endmodule

// File: rtl/tern_encode.sv
`timescale 1ns/1ps
module tern_encode
    import tern_pkg::*;
(
    input  logic              enc_lo,
    input  logic              enc_hi,
    output logic [TRIT_W-1:0] enc_out
);
    trit_e code;

    always_comb begin
        if (enc_hi) begin
            code = TR_TWO;
        end else if (enc_lo) begin
            code = TR_ONE;
        end else begin
            code = TR_ZERO;
        end
    end

    assign enc_out = code;

    // R8: the encoder never emits the illegal code
    always_comb begin
        if (!$isunknown({enc_lo, enc_hi})) begin
            a_r8_legal: assert (enc_out != TR_BAD)
                else $error("encoder produced illegal code");
        end
    end
endmodule

// File: rtl/tern_gate_unit.sv
`timescale 1ns/1ps
module tern_gate_unit
    import tern_pkg::*;
(
    input  logic                sel_min,
    input  logic [TRIT_W-1:0]   opa,
    input  logic [TRIT_W-1:0]   opb,
    output logic [TRIT_W-1:0]   inv_neg,
    output logic [TRIT_W-1:0]   inv_std,
    output logic [TRIT_W-1:0]   inv_pos,
    output logic                op_err,
    input  logic [TRIT_W-1:0]   dec_in,
    output logic [N_LEVELS-1:0] dec_flags,
    output logic                dec_err,
    input  logic                enc_lo,
    input  logic                enc_hi,
    output logic [TRIT_W-1:0]   enc_out
);
    trit_e mid;

    tern_minmax u_core (
        .sel_min (sel_min),
        .opa     (opa),
        .opb     (opb),
        .mid     (mid),
        .bad     (op_err)
    );

    tern_inv3 u_inv (
        .mid     (mid),
        .inv_neg (inv_neg),
        .inv_std (inv_std),
        .inv_pos (inv_pos)
    );

    tern_decode u_dec (
        .dec_in    (dec_in),
        .dec_flags (dec_flags),
        .dec_err   (dec_err)
    );

    tern_encode u_enc (
        .enc_lo  (enc_lo),
        .enc_hi  (enc_hi),
        .enc_out (enc_out)
    );

    // R5: an illegal operand silences every inverter output
    always_comb begin
        if (!$isunknown({sel_min, opa, opb}) && op_err) begin
            a_r5_err_silent: assert (inv_neg == '0 && inv_std == '0 && inv_pos == '0)
                else $error("inverter output active during operand error");
        end
    end
endmodule

// File: tb/tern_gate_unit_tb.sv
`timescale 1ns/1ps
module tern_gate_unit_tb;
    logic       clk = 1'b0;
    logic       sel_min;
    logic [1:0] opa, opb;
    logic [1:0] inv_neg, inv_std, inv_pos;
    logic       op_err;
    logic [1:0] dec_in;
    logic [2:0] dec_flags;
    logic       dec_err;
    logic       enc_lo, enc_hi;
    logic [1:0] enc_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    tern_gate_unit u_dut (
        .sel_min(sel_min), .opa(opa), .opb(opb),
        .inv_neg(inv_neg), .inv_std(inv_std), .inv_pos(inv_pos),
        .op_err(op_err),
        .dec_in(dec_in), .dec_flags(dec_flags), .dec_err(dec_err),
        .enc_lo(enc_lo), .enc_hi(enc_hi), .enc_out(enc_out)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic int ref_mid(input int a, input int b, input bit mn);
        if (mn) return (a < b) ? a : b;
        return (a > b) ? a : b;
    endfunction

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_idle();
        sel_min = 0; opa = 0; opb = 0; dec_in = 0; enc_lo = 0; enc_hi = 0;
        settle();
        chk("R2", "idle neg", int'(inv_neg), 2);
        chk("R3", "idle std", int'(inv_std), 2);
        chk("R4", "idle pos", int'(inv_pos), 2);
        chk("R5", "idle err", int'(op_err), 0);
        chk("R6", "idle flags", int'(dec_flags), 1);
        chk("R8", "idle enc", int'(enc_out), 0);
    endtask

    task automatic t_sweep();
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 3; a++) begin
                for (int b = 0; b < 3; b++) begin
                    int mv;
                    sel_min = m[0]; opa = 2'(a); opb = 2'(b);
                    settle();
                    mv = ref_mid(a, b, m[0]);
                    chk("R2", "sweep neg", int'(inv_neg), (mv == 0) ? 2 : 0);
                    chk("R3", "sweep std", int'(inv_std), 2 - mv);
                    chk("R4", "sweep pos", int'(inv_pos), (mv == 2) ? 0 : 2);
                    chk("R5", "sweep err", int'(op_err), 0);
                end
            end
        end
    endtask

    task automatic t_mode_flip();
        opa = 2'b00; opb = 2'b10;
        sel_min = 0; settle();
        chk("R1", "max of 0,2 std", int'(inv_std), 0);
        sel_min = 1; settle();
        chk("R1", "min of 0,2 std", int'(inv_std), 2);
        opa = 2'b01; opb = 2'b10; settle();
        chk("R1", "min of 1,2 std", int'(inv_std), 1);
    endtask

    task automatic t_bad_ops();
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 4; p++) begin
                sel_min = m[0];
                case (p)
                    0: begin opa = 2'b11; opb = 2'b00; end
                    1: begin opa = 2'b00; opb = 2'b11; end
                    2: begin opa = 2'b11; opb = 2'b11; end
                    default: begin opa = 2'b01; opb = 2'b11; end
                endcase
                settle();
                chk("R5", "bad err", int'(op_err), 1);
                chk("R5", "bad neg", int'(inv_neg), 0);
                chk("R5", "bad std", int'(inv_std), 0);
                chk("R5", "bad pos", int'(inv_pos), 0);
            end
        end
    endtask

    task automatic t_decode();
        for (int v = 0; v < 3; v++) begin
            dec_in = 2'(v);
            settle();
            chk("R6", "dec flags", int'(dec_flags), 1 << v);
            chk("R6", "dec err", int'(dec_err), 0);
        end
        dec_in = 2'b11;
        settle();
        chk("R7", "dec bad flags", int'(dec_flags), 0);
        chk("R7", "dec bad err", int'(dec_err), 1);
    endtask

    task automatic t_encode();
        for (int c = 0; c < 4; c++) begin
            enc_lo = c[0]; enc_hi = c[1];
            settle();
            chk("R8", "enc out", int'(enc_out), c[1] ? 2 : (c[0] ? 1 : 0));
        end
    endtask

    initial begin
        t_idle();
        t_sweep();
        t_mode_flip();
        t_bad_ops();
        t_decode();
        t_encode();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule